// File: doc/BRIEF.md
# Page Write Buffer with Busy Polling

This block sits behind the slave front end of a serial memory device. The front end passes it the start address of a write transaction, one strobe per received data byte, the bus STOP event, and the bank bit. The block gathers the bytes in a 16-byte page buffer and, when STOP arrives, runs a timed internal write cycle. That cycle commits the gathered bytes to a behavioural two-bank memory array.

The address holds a 4-bit page number in its upper nibble and a 4-bit byte offset in its lower nibble. The byte pointer advances after every loaded byte and wraps inside the same page. Bytes beyond sixteen therefore replace earlier ones. A per-byte valid mask makes sure that only positions that were actually loaded get written. Each bank holds 16 pages of 16 bytes. Non-volatile programming time is modelled by a counter of `WRITE_CYCLES` clock cycles.

While the cycle runs, `busy` is high. The front end uses it to withhold the acknowledge of its slave address, so a bus master can poll for completion. A read port lets the front end, and the bench, fetch array contents.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy` is 0 and every array byte reads 0xFF through the read port.
- R2: A committed byte lands at array address {bank, page, offset}. The bank is in bit 8 and is taken from `bank_sel` at STOP. The page is `start_addr[7:4]`, and the starting offset is `start_addr[3:0]`.
- R3: The offset advances by one after each loaded byte and wraps from 15 to 0 without changing the page.
- R4: When more than 16 bytes are loaded, the last byte loaded into a position is the one committed there.
- R5: Positions of the page that received no byte keep their previous array contents.
- R6: A STOP with no byte loaded since the last address strobe leaves `busy` at 0 and changes no array byte.
- R7: `busy` goes high in the cycle after the STOP strobe and stays high for exactly `WRITE_CYCLES` cycles.
- R8: Address, byte and STOP strobes presented while `busy` is high have no effect on the array contents.
- R9: Bytes loaded before a fresh address strobe are discarded without any write. Loading bytes without a STOP starts no cycle and writes nothing.
- R10: The array write enable is asserted only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Start-address strobe for a write transaction |
| start_addr | input | 8 | Page (upper nibble) and byte offset (lower nibble) |
| byte_load | input | 1 | Data-byte strobe |
| byte_in | input | 8 | Data byte |
| stop_evt | input | 1 | Bus STOP strobe |
| bank_sel | input | 1 | Bank bit, captured at STOP |
| busy | output | 1 | Internal write cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_waddr | output | 9 | Array write address {bank, page, offset} |
| mem_wdata | output | 8 | Array write data |
| rd_addr | input | 9 | Array read address |
| rd_data | output | 8 | Array read data (combinational) |

## Verification
A STOP strobe captured at clock edge k makes `busy` visible in the sample just after edge k. The bench drives strobes on falling edges and samples `busy` on the next falling edge. It then counts consecutive high samples and expects exactly `WRITE_CYCLES` of them. Array contents are due once `busy` has fallen, because all commits happen within the busy window. Only then does the bench sweep the combinational read port and compare every byte against its own model.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    localparam int DATA_W = 8;
    localparam int PTR_W  = 4;
    localparam int PAGE_W = 4;
    localparam int BANK_W = 1;
    localparam int DEPTH  = 1 << PTR_W;
    localparam int SADR_W = PAGE_W + PTR_W;
    localparam int ARR_AW = BANK_W + SADR_W;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [PAGE_W-1:0] page_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        page_t             page;
        ptr_t              off;
    } arr_addr_t;

    typedef enum logic { SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1 } seq_state_t;

    function automatic ptr_t next_ptr(input ptr_t p);
        return p + ptr_t'(1);
    endfunction

    function automatic arr_addr_t mk_addr(input logic [BANK_W-1:0] b,
                                          input page_t pg, input ptr_t o);
        arr_addr_t a;
        a.bank = b;
        a.page = pg;
        a.off  = o;
        return a;
    endfunction
endpackage

// File: rtl/pwb_loader.sv
module pwb_loader
    import pwb_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        accept,
    input  logic                        addr_load,
    input  logic [SADR_W-1:0]           start_addr,
    input  logic                        byte_load,
    input  byte_t                       byte_in,
    input  logic                        clear_mask,
    output logic [DEPTH-1:0][DATA_W-1:0] buf_q,
    output logic [DEPTH-1:0]            mask_q,
    output page_t                       page_q
);
    ptr_t ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            mask_q <= '0;
            page_q <= '0;
            ptr_q  <= '0;
        end else if (clear_mask) begin
            mask_q <= '0;
        end else if (accept) begin
            if (addr_load) begin
                page_q <= start_addr[SADR_W-1:PTR_W];
                ptr_q  <= start_addr[PTR_W-1:0];
                mask_q <= '0;
            end else if (byte_load) begin
                buf_q[ptr_q]  <= byte_in;
                mask_q[ptr_q] <= 1'b1;
                ptr_q         <= next_ptr(ptr_q);
            end
        end
    end
endmodule

// File: rtl/pwb_sequencer.sv
module pwb_sequencer
    import pwb_pkg::*;
#(
    parameter int WRITE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_evt,
    input  logic              have_data,
    input  logic [BANK_W-1:0] bank_sel,
    output logic              busy,
    output logic              done,
    output logic              commit_act,
    output ptr_t              commit_idx,
    output logic [BANK_W-1:0] bank_q
);
    localparam int CNT_W = $clog2(WRITE_CYCLES);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(WRITE_CYCLES - 1);
    localparam logic [CNT_W-1:0] SPAN  = CNT_W'(DEPTH);

    seq_state_t       st_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SEQ_IDLE;
            cnt_q  <= '0;
            bank_q <= '0;
        end else begin
            case (st_q)
                SEQ_IDLE: if (stop_evt && have_data) begin
                    st_q   <= SEQ_RUN;
                    cnt_q  <= '0;
                    bank_q <= bank_sel;
                end
                SEQ_RUN: if (cnt_q == LAST) begin
                    st_q  <= SEQ_IDLE;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy       = (st_q == SEQ_RUN);
    assign done       = busy && (cnt_q == LAST);
    assign commit_act = busy && (cnt_q < SPAN);
    assign commit_idx = cnt_q[PTR_W-1:0];
endmodule

// File: rtl/pwb_array.sv
module pwb_array
    import pwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ARR_AW-1:0] waddr,
    input  byte_t             wdata,
    input  logic [ARR_AW-1:0] raddr,
    output byte_t             rdata
);
    localparam int WORDS = 1 << ARR_AW;

    byte_t mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
    import pwb_pkg::*;
#(
    parameter int WRITE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_load,
    input  logic [SADR_W-1:0] start_addr,
    input  logic              byte_load,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              stop_evt,
    input  logic              bank_sel,
    output logic              busy,
    output logic              mem_we,
    output logic [ARR_AW-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [ARR_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DEPTH-1:0][DATA_W-1:0] buf_q;
    logic [DEPTH-1:0]             mask_q;
    page_t                        page_q;
    logic                         done;
    logic                         commit_act;
    ptr_t                         commit_idx;
    logic [BANK_W-1:0]            bank_q;
    arr_addr_t                    wa;

    pwb_loader u_load (
        .clk        (clk),
        .rst        (rst),
        .accept     (!busy),
        .addr_load  (addr_load),
        .start_addr (start_addr),
        .byte_load  (byte_load),
        .byte_in    (byte_in),
        .clear_mask (done),
        .buf_q      (buf_q),
        .mask_q     (mask_q),
        .page_q     (page_q)
    );

    pwb_sequencer #(.WRITE_CYCLES(WRITE_CYCLES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .stop_evt   (stop_evt),
        .have_data  (|mask_q),
        .bank_sel   (bank_sel),
        .busy       (busy),
        .done       (done),
        .commit_act (commit_act),
        .commit_idx (commit_idx),
        .bank_q     (bank_q)
    );

    assign wa        = mk_addr(bank_q, page_q, commit_idx);
    assign mem_we    = commit_act && mask_q[commit_idx];
    assign mem_waddr = wa;
    assign mem_wdata = buf_q[commit_idx];

    pwb_array u_arr (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker
    import pwb_pkg::*;
#(
    parameter int WRITE_CYCLES = 40
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         busy,
    input logic                         stop_evt,
    input logic                         mem_we,
    input logic [ARR_AW-1:0]            mem_waddr,
    input page_t                        page_q,
    input logic [DEPTH-1:0]             mask_q,
    input logic [DEPTH-1:0][DATA_W-1:0] buf_q
);
    int run_len;

    always_ff @(posedge clk) begin
        if (rst) run_len <= 0;
        else     run_len <= busy ? run_len + 1 : 0;
    end

    // R10
    p_we_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R7
    p_busy_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_evt));

    // R7
    p_busy_len_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == WRITE_CYCLES));

    // R6
    p_empty_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (stop_evt && !busy && (mask_q == '0)) |=> !busy);

    // R8
    p_buf_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(buf_q));

    // R2
    p_waddr_page_r2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_waddr[SADR_W-1:PTR_W] == page_q));
endmodule

bind page_write_buffer pwb_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .stop_evt  (stop_evt),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .page_q    (page_q),
    .mask_q    (mask_q),
    .buf_q     (buf_q)
);

// File: tb/sim_page_write_buffer.sv
module sim_page_write_buffer;
    localparam int W = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr_load = 1'b0;
    logic [7:0] start_addr = '0;
    logic       byte_load = 1'b0;
    logic [7:0] byte_in = '0;
    logic       stop_evt = 1'b0;
    logic       bank_sel = 1'b0;
    logic       busy;
    logic       mem_we;
    logic [8:0] mem_waddr;
    logic [7:0] mem_wdata;
    logic [8:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit summary_done = 1'b0;

    logic [7:0] ref_mem [512];
    logic [7:0] ref_buf [16];
    logic [15:0] ref_mask;
    logic [3:0] ref_page;
    logic [3:0] ref_ptr;

    always #10 clk = ~clk;

    page_write_buffer #(.WRITE_CYCLES(W)) u0 (
        .clk(clk), .rst(rst), .addr_load(addr_load), .start_addr(start_addr),
        .byte_load(byte_load), .byte_in(byte_in), .stop_evt(stop_evt),
        .bank_sel(bank_sel), .busy(busy), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [8:0] arr_ix(input logic b, input logic [3:0] pg, input logic [3:0] o);
        return {b, pg, o};
    endfunction

    task automatic check_mem(input string req);
        int bad_ix = -1;
        int act = 0;
        int exp = 0;
        for (int a = 0; a < 512; a++) begin
            rd_addr = 9'(a);
            #1;
            if (bad_ix < 0 && rd_data !== ref_mem[a]) begin
                bad_ix = a; act = int'(rd_data); exp = int'(ref_mem[a]);
            end
        end
        if (bad_ix >= 0) $display("  first mismatch at array index %0d", bad_ix);
        check(bad_ix < 0, req, act, exp);
    endtask

    task automatic send_addr(input logic [7:0] a);
        @(negedge clk);
        addr_load = 1'b1; start_addr = a;
        @(negedge clk);
        addr_load = 1'b0;
        ref_page = a[7:4]; ref_ptr = a[3:0]; ref_mask = '0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk);
        byte_load = 1'b1; byte_in = d;
        @(negedge clk);
        byte_load = 1'b0;
        ref_buf[ref_ptr] = d; ref_mask[ref_ptr] = 1'b1; ref_ptr = ref_ptr + 4'd1;
    endtask

    // Issue STOP, follow the busy window, update the model, compare array.
    task automatic send_stop(input logic b, input bit inject, input string req);
        int cnt = 0;
        bit expect_busy;
        expect_busy = (ref_mask != 0);
        @(negedge clk);
        stop_evt = 1'b1; bank_sel = b;
        @(negedge clk);
        stop_evt = 1'b0;
        check(busy == expect_busy, expect_busy ? "R7 busy after STOP" : "R6 empty STOP", int'(busy), int'(expect_busy));
        while (busy && cnt < 1000) begin
            cnt++;
            if (inject) begin
                addr_load  = ($urandom % 4) == 0;
                start_addr = 8'($urandom);
                byte_load  = ($urandom % 2) == 0;
                byte_in    = 8'($urandom);
                stop_evt   = ($urandom % 3) == 0;
                bank_sel   = 1'($urandom);
            end
            @(negedge clk);
        end
        addr_load = 1'b0; byte_load = 1'b0; stop_evt = 1'b0;
        if (expect_busy) begin
            check(cnt == W, "R7 busy length", cnt, W);
            for (int i = 0; i < 16; i++)
                if (ref_mask[i]) ref_mem[arr_ix(b, ref_page, 4'(i))] = ref_buf[i];
            ref_mask = '0;
        end
        check_mem(req);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
        end
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        for (int a = 0; a < 512; a++) ref_mem[a] = 8'hFF;
        ref_mask = '0; ref_page = '0; ref_ptr = '0;
        for (int i = 0; i < 16; i++) ref_buf[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
        check_mem("R1 array erased");

        // R2 single byte
        send_addr(8'h35); send_byte(8'h5A);
        send_stop(1'b0, 1'b0, "R2 single byte placement");
        send_addr(8'hC0); send_byte(8'h11);
        send_stop(1'b1, 1'b0, "R2 upper bank placement");

        // R3 wrap within page
        send_addr(8'hAE);
        for (int i = 0; i < 4; i++) send_byte(8'(8'h20 + i));
        send_stop(1'b1, 1'b0, "R3 in-page wrap");

        // R4 more than 16 bytes
        send_addr(8'h50);
        for (int i = 0; i < 20; i++) send_byte(8'(8'h80 + i));
        send_stop(1'b0, 1'b0, "R4 overflow overwrite");

        // R5 partial page leaves neighbours
        send_addr(8'h53);
        for (int i = 0; i < 3; i++) send_byte(8'(8'h40 + i));
        send_stop(1'b0, 1'b0, "R5 untouched positions kept");

        // R6 empty STOP
        send_addr(8'h77);
        send_stop(1'b0, 1'b0, "R6 no write on empty STOP");

        // R9 bytes without STOP, then fresh address discards them
        send_addr(8'h10); send_byte(8'h99); send_byte(8'h98);
        repeat (5) @(negedge clk);
        check(busy == 1'b0, "R9 no cycle without STOP", int'(busy), 0);
        check_mem("R9 no write without STOP");
        send_addr(8'h18); send_byte(8'h33);
        send_stop(1'b0, 1'b0, "R9 fresh address discards bytes");

        // R8 strobes during busy ignored
        send_addr(8'h61); send_byte(8'h0F);
        send_stop(1'b1, 1'b1, "R8 strobes ignored while busy");

        // random mix; R10 covered by its property
        for (int t = 0; t < 25; t++) begin
            logic [7:0] a;
            int nb;
            a  = 8'($urandom);
            nb = int'($urandom % 21);
            send_addr(a);
            for (int i = 0; i < nb; i++) send_byte(8'($urandom));
            send_stop(1'($urandom), ($urandom % 2) == 0, "R2 R4 R5 random transaction");
        end

        if (!summary_done) begin
            summary_done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
        $finish;
    end
endmodule